// File: doc/BRIEF.md
# Tagged Operation Sampler

This block performs precise per-operation sampling. A programmable interval counter runs either on clock cycles or on dispatched micro-ops. When it expires, the block tags the next operation to be dispatched, identified by its tag ID. It then watches the completion stream for that tag. When the tagged operation completes, the block latches that operation's own instruction pointer. For a load or store it also latches the data linear address and the cache-miss latency. No other operation's state can enter the sample, so the recorded pointer has zero skid.

The pipeline itself is not part of the block. It is represented by three strobe interfaces: dispatch, completion and flush. Software programs a control word and an interval. A level-sensitive interrupt signals a held sample. Software reads the sample fields and then pulses a clear input to start the next interval. The low bits of the interval can optionally be replaced from a pseudo-random generator. This spreads samples and avoids shadowing right after each re-arm.

Top module: `tos_sampler`

## Requirements
- R1: During and after reset, `smp_valid_o` and `irq_o` are 0 and every sample field reads 0.
- R2: Control bit 0 enables the sampler. When control bit 19 is 0, the interval counts clock cycles. After arming, the counter is loaded on the first clock edge. It then expires N edges later, where N is the reload value. The first dispatch seen on a later edge is tagged.
- R3: When control bit 19 is 1, the interval counts dispatch strobes. The dispatch that follows the Nth counted dispatch, in a later cycle, is tagged. A reload value of 0 behaves as 1.
- R4: On a completion whose tag matches the tagged operation, the sample is captured and `smp_valid_o` rises on that edge. The sample holds the tagged operation's dispatch IP and the completion latency. Completions with any other tag are ignored.
- R5: `smp_addr_ok_o` equals the tagged operation's memory flag (load or store). For an operation that is not a memory access, `smp_addr_o` and `smp_lat_o` read 0.
- R6: `smp_ip_ok_o` copies the completion's pointer-capture-good input. A 0 tells consumers to use a non-exact pointer.
- R7: While an operation is tagged, later dispatches are not tagged. While a sample is valid, sampling is halted, and repeat completions of the tag leave the sample unchanged.
- R8: A flush whose tag matches the tagged operation discards the tag and re-arms the interval without producing a sample. A flush wins over a matching completion in the same cycle. A flush with any other tag is ignored.
- R9: A pulse on `sw_clear_i` while a sample is held clears `smp_valid_o` on the next edge and re-arms the interval.
- R10: When control bit 2 is 1, bits 3:0 of the reload value are replaced by bits 3:0 of a 16-bit LFSR. The LFSR is seeded with 0xACE1 and shifts left, with new bit 0 = b15^b13^b12^b10. It advances once on each interval load.
- R11: `irq_o` is high exactly while a sample is valid and control bit 1 is 1.
- R12: When control bit 0 is 0, the counter stays unloaded and any outstanding tag is dropped. A sample that is already held remains valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_i | input | 32 | Control word: bit0 enable, bit1 interrupt enable, bit2 randomize, bit19 count ops |
| interval_i | input | CNT_W | Interval reload value |
| sw_clear_i | input | 1 | Clears a held sample and re-arms |
| disp_valid_i | input | 1 | Dispatch strobe |
| disp_tag_i | input | TAG_W | Tag of the dispatched operation |
| disp_ip_i | input | IP_W | Instruction pointer of the dispatched operation |
| disp_mem_i | input | 1 | Dispatched operation is a load or store |
| cmpl_valid_i | input | 1 | Completion strobe |
| cmpl_tag_i | input | TAG_W | Tag of the completing operation |
| cmpl_ip_ok_i | input | 1 | Pointer capture succeeded for this operation |
| cmpl_addr_i | input | ADDR_W | Data linear address of the access |
| cmpl_lat_i | input | LAT_W | Cache-miss latency of the access |
| flush_valid_i | input | 1 | Flush strobe |
| flush_tag_i | input | TAG_W | Tag of the flushed operation |
| smp_valid_o | output | 1 | Sample held, waiting for software |
| smp_ip_o | output | IP_W | Sampled instruction pointer |
| smp_ip_ok_o | output | 1 | Sampled pointer is exact |
| smp_addr_o | output | ADDR_W | Sampled data address |
| smp_addr_ok_o | output | 1 | Sampled data address is meaningful |
| smp_lat_o | output | LAT_W | Sampled latency |
| irq_o | output | 1 | Level interrupt |

## Verification
Most corrupted internal state shows up at the sample ports within the next completion. A miscounted interval, a lost tag or a wrong LFSR step tags a different operation, so the captured pointer differs from the model's in the cycle that `smp_valid_o` rises. A stuck phase either never raises `smp_valid_o` or raises it after a flush, and the per-cycle comparison catches this on that edge. Interrupt-gating faults show on `irq_o` in the same cycle that the control bit or the valid flag changes.

// File: rtl/tos_pkg.sv
package tos_pkg;
    localparam int CTRL_W  = 32;
    localparam int CB_EN   = 0;
    localparam int CB_IRQ  = 1;
    localparam int CB_RAND = 2;
    localparam int CB_OPS  = 19;

    typedef enum logic [2:0] {
        PH_LOAD  = 3'd0,
        PH_COUNT = 3'd1,
        PH_ARMED = 3'd2,
        PH_TRACK = 3'd3,
        PH_HOLD  = 3'd4
    } phase_e;
endpackage

// File: rtl/tos_lfsr.sv
module tos_lfsr #(
    parameter int          RND_W = 4,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [RND_W-1:0] rnd_o
);
    logic [15:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (step_i) begin
            lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign rnd_o = lfsr_q[RND_W-1:0];

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0000); // R10
endmodule

// File: rtl/tos_interval.sv
module tos_interval #(
    parameter int CNT_W = 20,
    parameter int RND_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             inc_i,
    input  logic             rnd_en_i,
    input  logic [CNT_W-1:0] base_i,
    input  logic [RND_W-1:0] rnd_i,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        reload = base_i;
        if (rnd_en_i) reload[RND_W-1:0] = rnd_i;
        if (reload == '0) reload = CNT_ONE;
    end

    assign ovf_o = inc_i && (cnt_q == CNT_ONE);

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = reload;
        else if (inc_i && !ovf_o) cnt_d = cnt_q - CNT_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> cnt_q != '0); // R2
endmodule

// File: rtl/tos_sampler.sv
module tos_sampler
    import tos_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int IP_W   = 32,
    parameter int ADDR_W = 32,
    parameter int LAT_W  = 12,
    parameter int CNT_W  = 20,
    parameter int RND_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [CNT_W-1:0]  interval_i,
    input  logic              sw_clear_i,
    input  logic              disp_valid_i,
    input  logic [TAG_W-1:0]  disp_tag_i,
    input  logic [IP_W-1:0]   disp_ip_i,
    input  logic              disp_mem_i,
    input  logic              cmpl_valid_i,
    input  logic [TAG_W-1:0]  cmpl_tag_i,
    input  logic              cmpl_ip_ok_i,
    input  logic [ADDR_W-1:0] cmpl_addr_i,
    input  logic [LAT_W-1:0]  cmpl_lat_i,
    input  logic              flush_valid_i,
    input  logic [TAG_W-1:0]  flush_tag_i,
    output logic              smp_valid_o,
    output logic [IP_W-1:0]   smp_ip_o,
    output logic              smp_ip_ok_o,
    output logic [ADDR_W-1:0] smp_addr_o,
    output logic              smp_addr_ok_o,
    output logic [LAT_W-1:0]  smp_lat_o,
    output logic              irq_o
);
    typedef struct packed {
        phase_e             phase;
        logic [TAG_W-1:0]   tag;
        logic [IP_W-1:0]    tag_ip;
        logic               tag_mem;
        logic               s_valid;
        logic [IP_W-1:0]    s_ip;
        logic               s_ip_ok;
        logic [ADDR_W-1:0]  s_addr;
        logic               s_addr_ok;
        logic [LAT_W-1:0]   s_lat;
    } st_t;

    st_t st_d, st_q;

    logic en, ops_mode;
    logic load, inc, ovf;
    logic hit_flush, hit_cmpl;
    logic [RND_W-1:0] rnd;
    logic unused_ctrl;

    assign en          = ctrl_i[CB_EN];
    assign ops_mode    = ctrl_i[CB_OPS];
    assign unused_ctrl = ^{ctrl_i[CTRL_W-1:CB_OPS+1], ctrl_i[CB_OPS-1:CB_RAND+1]};

    assign load      = (st_q.phase == PH_LOAD) && en;
    assign inc       = (st_q.phase == PH_COUNT) && en && (ops_mode ? disp_valid_i : 1'b1);
    assign hit_flush = flush_valid_i && (flush_tag_i == st_q.tag);
    assign hit_cmpl  = cmpl_valid_i && (cmpl_tag_i == st_q.tag);

    tos_lfsr #(.RND_W(RND_W)) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (load),
        .rnd_o  (rnd)
    );

    tos_interval #(.CNT_W(CNT_W), .RND_W(RND_W)) u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .inc_i    (inc),
        .rnd_en_i (ctrl_i[CB_RAND]),
        .base_i   (interval_i),
        .rnd_i    (rnd),
        .ovf_o    (ovf)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.phase == PH_HOLD) begin
            if (sw_clear_i) begin
                st_d.s_valid = 1'b0;
                st_d.phase   = PH_LOAD;
            end
        end else if (!en) begin
            st_d.phase = PH_LOAD;
        end else begin
            case (st_q.phase)
                PH_LOAD:  st_d.phase = PH_COUNT;
                PH_COUNT: if (ovf) st_d.phase = PH_ARMED;
                PH_ARMED: begin
                    if (disp_valid_i) begin
                        st_d.tag     = disp_tag_i;
                        st_d.tag_ip  = disp_ip_i;
                        st_d.tag_mem = disp_mem_i;
                        st_d.phase   = PH_TRACK;
                    end
                end
                PH_TRACK: begin
                    if (hit_flush) begin
                        st_d.phase = PH_LOAD;
                    end else if (hit_cmpl) begin
                        st_d.s_valid   = 1'b1;
                        st_d.s_ip      = st_q.tag_ip;
                        st_d.s_ip_ok   = cmpl_ip_ok_i;
                        st_d.s_addr_ok = st_q.tag_mem;
                        st_d.s_addr    = st_q.tag_mem ? cmpl_addr_i : '0;
                        st_d.s_lat     = st_q.tag_mem ? cmpl_lat_i : '0;
                        st_d.phase     = PH_HOLD;
                    end
                end
                default: st_d.phase = PH_LOAD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_valid_o   = st_q.s_valid;
    assign smp_ip_o      = st_q.s_ip;
    assign smp_ip_ok_o   = st_q.s_ip_ok;
    assign smp_addr_o    = st_q.s_addr;
    assign smp_addr_ok_o = st_q.s_addr_ok;
    assign smp_lat_o     = st_q.s_lat;
    assign irq_o         = st_q.s_valid && ctrl_i[CB_IRQ];

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o && !sw_clear_i |=> smp_valid_o); // R7
    AST_SAMPLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o && !sw_clear_i |=> $stable(smp_ip_o) && $stable(smp_addr_o) && $stable(smp_lat_o)); // R7
    AST_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase == PH_TRACK && en && !hit_flush && !hit_cmpl |=> $stable(st_q.tag)); // R7
    AST_ADDR_NONMEM: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o && !smp_addr_ok_o |-> smp_addr_o == '0 && smp_lat_o == '0); // R5
    AST_FLUSH_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase == PH_TRACK && en && hit_flush |=> !smp_valid_o); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o && sw_clear_i |=> !smp_valid_o); // R9
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> smp_valid_o); // R11
endmodule

// File: tb/tb_tos_sampler.sv
`timescale 1ns/1ps
module tb_tos_sampler;
    localparam int TAG_W = 6, IP_W = 32, ADDR_W = 32, LAT_W = 12, CNT_W = 20;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [31:0]       ctrl_i = '0;
    logic [CNT_W-1:0]  interval_i = '0;
    logic              sw_clear_i = 1'b0;
    logic              disp_valid_i = 1'b0;
    logic [TAG_W-1:0]  disp_tag_i = '0;
    logic [IP_W-1:0]   disp_ip_i = '0;
    logic              disp_mem_i = 1'b0;
    logic              cmpl_valid_i = 1'b0;
    logic [TAG_W-1:0]  cmpl_tag_i = '0;
    logic              cmpl_ip_ok_i = 1'b0;
    logic [ADDR_W-1:0] cmpl_addr_i = '0;
    logic [LAT_W-1:0]  cmpl_lat_i = '0;
    logic              flush_valid_i = 1'b0;
    logic [TAG_W-1:0]  flush_tag_i = '0;
    logic              smp_valid_o, smp_ip_ok_o, smp_addr_ok_o, irq_o;
    logic [IP_W-1:0]   smp_ip_o;
    logic [ADDR_W-1:0] smp_addr_o;
    logic [LAT_W-1:0]  smp_lat_o;

    tos_sampler dut (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    localparam int P_LOAD = 0, P_COUNT = 1, P_ARMED = 2, P_TRACK = 3, P_HOLD = 4;
    int          m_phase, m_rem;
    logic [15:0] m_lfsr;
    logic [TAG_W-1:0] m_tag;
    logic [IP_W-1:0]  m_ip, m_sip;
    logic        m_mem, m_valid, m_sipok, m_saddr_ok;
    logic [ADDR_W-1:0] m_saddr;
    logic [LAT_W-1:0]  m_slat;

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    always @(posedge clk) begin
        logic [CNT_W-1:0] rl;
        if (!rst_n) begin
            m_phase = P_LOAD; m_rem = 0; m_lfsr = 16'hACE1; m_tag = '0; m_ip = '0; m_mem = 0;
            m_valid = 0; m_sip = '0; m_sipok = 0; m_saddr = '0; m_saddr_ok = 0; m_slat = '0;
        end else if (m_phase == P_HOLD) begin
            if (sw_clear_i) begin m_valid = 0; m_phase = P_LOAD; end
        end else if (!ctrl_i[0]) begin
            m_phase = P_LOAD;
        end else if (m_phase == P_LOAD) begin
            rl = interval_i;
            if (ctrl_i[2]) rl[3:0] = m_lfsr[3:0];
            m_rem = (rl == 0) ? 1 : int'(rl);
            m_lfsr = lfsr_next(m_lfsr);
            m_phase = P_COUNT;
        end else if (m_phase == P_COUNT) begin
            if (ctrl_i[19] ? disp_valid_i : 1'b1) begin
                if (m_rem == 1) m_phase = P_ARMED;
                else m_rem = m_rem - 1;
            end
        end else if (m_phase == P_ARMED) begin
            if (disp_valid_i) begin
                m_tag = disp_tag_i; m_ip = disp_ip_i; m_mem = disp_mem_i; m_phase = P_TRACK;
            end
        end else begin
            if (flush_valid_i && flush_tag_i == m_tag) m_phase = P_LOAD;
            else if (cmpl_valid_i && cmpl_tag_i == m_tag) begin
                m_valid = 1; m_sip = m_ip; m_sipok = cmpl_ip_ok_i; m_saddr_ok = m_mem;
                m_saddr = m_mem ? cmpl_addr_i : '0;
                m_slat  = m_mem ? cmpl_lat_i : '0;
                m_phase = P_HOLD;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R4",  "valid",   64'(smp_valid_o),   64'(m_valid));
            chk("R4",  "ip",      64'(smp_ip_o),      64'(m_sip));
            chk("R4",  "lat",     64'(smp_lat_o),     64'(m_slat));
            chk("R5",  "addr",    64'(smp_addr_o),    64'(m_saddr));
            chk("R5",  "addr_ok", 64'(smp_addr_ok_o), 64'(m_saddr_ok));
            chk("R6",  "ip_ok",   64'(smp_ip_ok_o),   64'(m_sipok));
            chk("R11", "irq",     64'(irq_o),         64'(m_valid && ctrl_i[1]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic disp(input logic [TAG_W-1:0] t, input logic [IP_W-1:0] ip, input logic mem);
        disp_valid_i = 1; disp_tag_i = t; disp_ip_i = ip; disp_mem_i = mem;
        @(negedge clk);
        disp_valid_i = 0;
    endtask

    task automatic cmpl(input logic [TAG_W-1:0] t, input logic ok, input logic [ADDR_W-1:0] a, input logic [LAT_W-1:0] l);
        cmpl_valid_i = 1; cmpl_tag_i = t; cmpl_ip_ok_i = ok; cmpl_addr_i = a; cmpl_lat_i = l;
        @(negedge clk);
        cmpl_valid_i = 0;
    endtask

    task automatic flush(input logic [TAG_W-1:0] t);
        flush_valid_i = 1; flush_tag_i = t;
        @(negedge clk);
        flush_valid_i = 0;
    endtask

    task automatic clear();
        sw_clear_i = 1;
        @(negedge clk);
        sw_clear_i = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        ctrl_i = 32'h0008_0003;          // enable, irq enable, count ops
        interval_i = 20'd3;
        idle(3);
        chk("R1", "reset valid", 64'(smp_valid_o), 64'd0);
        chk("R1", "reset irq",   64'(irq_o),       64'd0);
        chk("R1", "reset ip",    64'(smp_ip_o),    64'd0);
        rst_n = 1;
        idle(3);

        // R3: op mode, interval 3 -> fourth dispatch tagged
        disp(1, 32'h101, 0); disp(2, 32'h102, 0); disp(3, 32'h103, 0); disp(4, 32'h104, 1);
        disp(5, 32'h105, 1);
        cmpl(2, 1, 32'h999, 12'd5);
        chk("R4", "other tag ignored", 64'(smp_valid_o), 64'd0);
        cmpl(4, 1, 32'hDEAD0, 12'd77);
        chk("R3", "tagged ip", 64'(smp_ip_o), 64'h104);
        chk("R4", "valid rises", 64'(smp_valid_o), 64'd1);
        chk("R5", "addr", 64'(smp_addr_o), 64'hDEAD0);
        chk("R4", "lat", 64'(smp_lat_o), 64'd77);
        chk("R11", "irq high", 64'(irq_o), 64'd1);

        // R7: sampling halted while valid
        disp(6, 32'h106, 1);
        cmpl(4, 0, 32'h1, 12'd1);
        idle(5);
        chk("R7", "ip unchanged", 64'(smp_ip_o), 64'h104);
        chk("R7", "lat unchanged", 64'(smp_lat_o), 64'd77);

        // R11: interrupt gated by control bit 1
        ctrl_i[1] = 0;
        @(negedge clk);
        chk("R11", "irq masked", 64'(irq_o), 64'd0);
        ctrl_i[1] = 1;

        // R9: clear
        clear();
        chk("R9", "valid cleared", 64'(smp_valid_o), 64'd0);
        chk("R9", "irq cleared", 64'(irq_o), 64'd0);

        // R2/R5/R6: cycle mode, interval 2, non-memory op, bad pointer
        ctrl_i = 32'h0000_0003; interval_i = 20'd2;
        idle(6);
        disp(9, 32'h200, 0);
        disp(10, 32'h201, 1);
        cmpl(9, 0, 32'h55, 12'd9);
        chk("R2", "first dispatch tagged", 64'(smp_ip_o), 64'h200);
        chk("R5", "nonmem addr_ok", 64'(smp_addr_ok_o), 64'd0);
        chk("R5", "nonmem addr zero", 64'(smp_addr_o), 64'd0);
        chk("R6", "ip_ok low", 64'(smp_ip_ok_o), 64'd0);
        clear();

        // R8: flush discards and re-arms
        idle(6);
        disp(3, 32'h300, 1);
        flush(5);
        flush(3);
        idle(2);
        chk("R8", "no sample after flush", 64'(smp_valid_o), 64'd0);
        idle(6);
        disp(6, 32'h600, 1);
        cmpl(3, 1, 32'h33, 12'd3);
        chk("R8", "stale completion ignored", 64'(smp_valid_o), 64'd0);
        cmpl(6, 1, 32'h66, 12'd6);
        chk("R8", "re-armed sample ip", 64'(smp_ip_o), 64'h600);

        // R12: disable keeps held sample, drops outstanding tag
        ctrl_i[0] = 0;
        idle(3);
        chk("R12", "held sample kept", 64'(smp_valid_o), 64'd1);
        chk("R12", "held ip kept", 64'(smp_ip_o), 64'h600);
        ctrl_i[0] = 1;
        clear();
        idle(6);
        disp(7, 32'h700, 0);
        ctrl_i[0] = 0;
        idle(1);
        ctrl_i[0] = 1;
        cmpl(7, 1, 32'h77, 12'd7);
        chk("R12", "dropped tag no sample", 64'(smp_valid_o), 64'd0);

        // R10 and mixed traffic against the model
        ctrl_i = 32'h0000_0007; interval_i = 20'h10;
        for (int i = 0; i < 1200; i++) begin
            if (i == 600) ctrl_i[19] = 1;
            disp_valid_i = (i % 3 != 1); disp_tag_i = TAG_W'(i); disp_ip_i = 32'h1_0000 + i;
            disp_mem_i = i[0];
            cmpl_valid_i = (i >= 4); cmpl_tag_i = TAG_W'(i - 4); cmpl_ip_ok_i = (i % 5 != 0);
            cmpl_addr_i = 32'hA000 + i; cmpl_lat_i = LAT_W'(i);
            flush_valid_i = (i % 7 == 0); flush_tag_i = TAG_W'(i - 2);
            sw_clear_i = smp_valid_o;
            if (smp_valid_o) chk("R10", "randomized sample ip", 64'(smp_ip_o), 64'(m_sip));
            @(negedge clk);
        end
        disp_valid_i = 0; cmpl_valid_i = 0; flush_valid_i = 0; sw_clear_i = 0;
        idle(4);
        finish_run();
    end
endmodule